// File: doc/BRIEF.md
# Serial LED Status Frame Shifter

This block streams a 30-bit LED status word to off-chip LED hardware over three wires: a serial clock, a serial data line and a latch strobe. It sends one fixed 36-clock frame after another and never stops. Each frame has a leading marker position, two filler positions, the 30 status bits, and three trailing filler positions. The serial clock comes from the system clock through a programmable divider with a 50% duty cycle. Every output is a flop in the system clock domain.

Two target styles are supported. In the start-marker mode the first position of every frame is driven high, so a serial display driver can find the frame boundary; the latch line stays low. In the latch mode the first position is low and a latch pulse is driven during the low half of the final serial clock, so a chain of 8-bit shift-and-latch registers updates once per frame after all bits are in.

The status word is copied into a shadow register at each frame boundary, so one frame never mixes old and new status. After reset the serial clock idles low. One low half-period is spent presenting the first bit, and the first rising edge then opens frame position 1.

Top module: `led_frame_shifter`

## Requirements
- R1: A frame is exactly 36 serial clock periods, where a period runs from one rising edge to the next. Position 36 is followed directly by position 1 of the next frame.
- R2: With `mode_i` = 0 (start-marker mode), the data value sampled at the rising edge of position 1 is 1.
- R3: The data values at positions 2, 3, 34, 35 and 36 are always 0 in both modes.
- R4: At positions 4 to 33, the data value is status bit `led_i[p-4]`, where p is the position. So `led_i[0]` is sent first, and a 1 means the LED is lit.
- R5: `led_data_o` changes only on system clock edges where `led_clk_o` falls, with one exception: the single priming update before the first rising edge. Data is therefore stable across every rising edge and through the whole high half-period.
- R6: With `mode_i` = 1 (latch mode), `led_latch_o` is high exactly during the low half of position 36. It rises together with the falling edge of position 36 and drops together with the next rising edge.
- R7: With `mode_i` = 0, `led_latch_o` stays low.
- R8: With `mode_i` = 1, the data value at position 1 is 0.
- R9: Each high half and each low half of `led_clk_o` lasts `half_i`+1 system clock cycles.
- R10: A frame carries the value of `led_i` present at the system clock edge where position 36 of the previous frame falls. For the first frame, it is the value at the priming edge. Changes to `led_i` between those edges do not reach the serial data.
- R11: While `rst_n` is low, all three outputs are 0. After release, the first rising edge of `led_clk_o` happens on the 2*(`half_i`+1)-th system clock edge, and that rising edge opens position 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 0 = start-marker mode, 1 = latch mode |
| half_i | input | 8 | Serial clock half-period in system clocks, minus one |
| led_i | input | 30 | LED status word, bit 0 sent first, 1 = on |
| led_clk_o | output | 1 | Serial clock |
| led_data_o | output | 1 | Serial data, launched on the falling edge |
| led_latch_o | output | 1 | Latch strobe, used in latch mode only |

## Verification
The bench sweeps both modes across divider settings 0, 1 and 3, runs several whole frames for each, and checks every rising edge against a bit computed from the frame position. The wrap from position 36 back to 1 is a key corner. An off-by-one frame counter would shift the marker and the status bits by one position each frame, so the errors would pile up. The latch pulse is checked on every system clock. A latch placed in the high half, or one cycle early, would update the external registers while the last bit is still shifting in. The status word is changed at arbitrary points in mid-frame; a design without the shadow copy would send a torn frame. The first rising edge after reset is timed exactly; a design that skipped the priming step would clock out an undefined first bit.

// File: rtl/led_frame_pkg.sv
package led_frame_pkg;

    typedef enum logic {
        LED_MODE_START = 1'b0,
        LED_MODE_LATCH = 1'b1
    } led_mode_e;

endpackage

// File: rtl/led_clk_div.sv
module led_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    // The >= guards against a setting lowered below the running count.
    assign tick_o = (cnt_q >= half_i);

    always_comb begin
        cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/led_frame_bitsel.sv
module led_frame_bitsel
    import led_frame_pkg::*;
#(
    parameter int LED_N     = 30,
    parameter int FIRST_LED = 3,
    parameter int IDX_W     = 6
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic             mode_i,
    input  logic [LED_N-1:0] word_i,
    output logic             bit_o
);

    logic [LED_N-1:0] hit;

    // One comparator per status bit; position zero is the frame marker.
    for (genvar j = 0; j < LED_N; j++) begin : g_hit
        assign hit[j] = word_i[j] && (idx_i == IDX_W'(FIRST_LED + j));
    end

    always_comb begin
        if (idx_i == '0) bit_o = (led_mode_e'(mode_i) == LED_MODE_START);
        else             bit_o = |hit;
    end

endmodule

// File: rtl/led_frame_shifter.sv
module led_frame_shifter
    import led_frame_pkg::*;
#(
    parameter int LED_N    = 30,
    parameter int HEAD_PAD = 2,
    parameter int TAIL_PAD = 3,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [DIV_W-1:0] half_i,
    input  logic [LED_N-1:0] led_i,
    output logic             led_clk_o,
    output logic             led_data_o,
    output logic             led_latch_o
);

    localparam int FRAME_LEN = 1 + HEAD_PAD + LED_N + TAIL_PAD;
    localparam int FIRST_LED = 1 + HEAD_PAD;
    localparam int IDX_W     = $clog2(FRAME_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

    typedef struct packed {
        logic             sclk;
        logic             data;
        logic             latch;
        logic             prime;
        logic [IDX_W-1:0] idx;
        logic [LED_N-1:0] word;
    } state_t;

    state_t           st_d, st_q;
    logic             tick;
    logic             next_bit;
    logic [IDX_W-1:0] next_idx;
    logic             at_last;

    led_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .half_i (half_i),
        .tick_o (tick)
    );

    assign at_last  = (st_q.idx == LAST_IDX);
    assign next_idx = at_last ? '0 : IDX_W'(st_q.idx + 1'b1);

    // Position zero ignores the word, so the shadow copy may load on the same edge.
    led_frame_bitsel #(
        .LED_N     (LED_N),
        .FIRST_LED (FIRST_LED),
        .IDX_W     (IDX_W)
    ) u_bitsel (
        .idx_i  (next_idx),
        .mode_i (mode_i),
        .word_i (st_q.word),
        .bit_o  (next_bit)
    );

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (st_q.prime) begin
                // Present position 1 during the first low half, with no clock edge.
                st_d.prime = 1'b0;
                st_d.idx   = next_idx;
                st_d.data  = next_bit;
                st_d.word  = led_i;
            end else if (!st_q.sclk) begin
                st_d.sclk  = 1'b1;
                st_d.latch = 1'b0;
            end else begin
                st_d.sclk  = 1'b0;
                st_d.idx   = next_idx;
                st_d.data  = next_bit;
                st_d.latch = at_last && (led_mode_e'(mode_i) == LED_MODE_LATCH);
                if (at_last) st_d.word = led_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sclk  <= 1'b0;
            st_q.data  <= 1'b0;
            st_q.latch <= 1'b0;
            st_q.prime <= 1'b1;
            st_q.idx   <= LAST_IDX;
            st_q.word  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign led_clk_o   = st_q.sclk;
    assign led_data_o  = st_q.data;
    assign led_latch_o = st_q.latch;

endmodule

// File: rtl/led_frame_shifter_chk.sv
module led_frame_shifter_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_i,
    input logic led_clk_o,
    input logic led_data_o,
    input logic led_latch_o
);

    // R5: data does not move on a rising edge
    a_r5_hold_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_clk_o) |-> $stable(led_data_o));

    // R5: data does not move while the serial clock stays high
    a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (led_clk_o && $past(led_clk_o)) |-> $stable(led_data_o));

    // R7: no latch in start-marker mode
    a_r7_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |-> !led_latch_o);

    // R6: latch only while the serial clock is low
    a_r6_latch_low: assert property (@(posedge clk) disable iff (!rst_n)
        led_latch_o |-> !led_clk_o);

    // R6: latch opens with a falling edge
    a_r6_latch_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_latch_o) |-> $fell(led_clk_o));

    // R6: latch closes with the next rising edge
    a_r6_latch_close: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(led_latch_o) |-> $rose(led_clk_o));

endmodule

bind led_frame_shifter led_frame_shifter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .led_clk_o   (led_clk_o),
    .led_data_o  (led_data_o),
    .led_latch_o (led_latch_o)
);

// File: tb/led_frame_shifter_tb.sv
module led_frame_shifter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic [7:0]  half_i = '0;
    logic [29:0] led_i = '0;
    logic        led_clk_o, led_data_o, led_latch_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit          mon_en = 0;
    logic        prev_clk, prev_data;
    int          rises, nclk, since;
    logic [29:0] word_m;
    logic [29:0] lfsr = 30'h1234_5677;

    always #5 clk = ~clk;

    led_frame_shifter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (mode_i),
        .half_i      (half_i),
        .led_i       (led_i),
        .led_clk_o   (led_clk_o),
        .led_data_o  (led_data_o),
        .led_latch_o (led_latch_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input int k);
        if (k == 0)             return ~mode_i;
        if (k >= 3 && k <= 32)  return word_m[k-3];
        return 1'b0;
    endfunction

    function automatic logic [29:0] step(input logic [29:0] x);
        return {x[28:0], x[29] ^ x[28] ^ x[25] ^ x[23]};
    endfunction

    always @(negedge clk) begin
        if (mon_en) begin
            int  k;
            bit  rose, fell;
            logic el;
            nclk++;
            since++;
            rose = (led_clk_o && !prev_clk);
            fell = (!led_clk_o && prev_clk);
            if (rose || fell) begin
                if (rises == 0 && rose)
                    chk(nclk == 2*(half_i+1), "R11 first rise clock", nclk, 2*(half_i+1));
                else
                    chk(since == half_i+1, "R9 half period", since, half_i+1);
                since = 0;
            end
            if (rose) begin
                k = rises % 36;
                if (k == 0)
                    chk(led_data_o == exp_bit(k), mode_i ? "R1/R8 position 1" : "R1/R2 start bit",
                        led_data_o, exp_bit(k));
                else if (k >= 3 && k <= 32)
                    chk(led_data_o == exp_bit(k), "R4/R10 status bit", led_data_o, exp_bit(k));
                else
                    chk(led_data_o == exp_bit(k), "R3 pad bit", led_data_o, exp_bit(k));
                rises++;
            end
            if (fell && ((rises-1) % 36 == 35)) word_m = led_i;  // R10 capture edge
            if (led_data_o != prev_data)
                chk(fell || rises == 0, "R5 data change off falling edge", led_data_o, prev_data);
            el = mode_i && !led_clk_o && rises > 0 && ((rises-1) % 36 == 35);
            chk(led_latch_o == el, mode_i ? "R6 latch" : "R7 latch", led_latch_o, el);
            prev_clk  = led_clk_o;
            prev_data = led_data_o;
        end
    end

    task automatic run_cfg(input logic m, input logic [7:0] h, input logic [29:0] first);
        int cnt = 0;
        @(negedge clk);
        mon_en = 0;
        rst_n  = 1'b0;
        mode_i = m;
        half_i = h;
        led_i  = first;
        repeat (3) begin
            @(negedge clk);
            chk(!led_clk_o && !led_data_o && !led_latch_o, "R11 reset outputs",
                {led_clk_o, led_data_o, led_latch_o}, 0);
        end
        #1;
        rst_n = 1'b1;
        word_m = led_i;
        prev_clk = 1'b0; prev_data = 1'b0;
        rises = 0; nclk = 0; since = 0;
        mon_en = 1;
        repeat (4*72*(h+1) + 10) begin
            @(negedge clk);
            #1;
            if (rises > 0) begin
                cnt++;
                if (cnt % 53 == 0) begin
                    lfsr  = step(lfsr);
                    led_i = lfsr;
                end
            end
        end
        @(negedge clk);
        mon_en = 0;
    endtask

    initial begin
        logic [7:0]  halves [3];
        logic [29:0] pats   [3];
        halves = '{8'd0, 8'd1, 8'd3};
        pats   = '{30'h2AAA_AAAA, 30'h1555_5555, 30'h3FFF_FFFF};
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 3; i++) begin
                run_cfg(m[0], halves[i], pats[i]);
            end
        end
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule